// File: doc/BRIEF.md
# Online Checked Ternary Copy Unit

This combinational block fans ternary values out to several lines and keeps a concurrent self-check on the copies. Every trit is carried on two wires as an unsigned binary number 0, 1 or 2; the code 3 is never applied. A one-bit mode picks the fan-out pattern. One pattern gives three copies of trit A. The other gives two copies of A and two copies of B. A first stage creates four data trits and a weighted parity trit Q from a seed trit P. A second stage passes the four data trits through unchanged. It also folds the data into a check trit S, starting from a reference trit R.

When nothing is faulty and R is set one above P (mod 3), S is the successor of Q. The error flag is high whenever that relation fails. A fault-injection select on each data line adds one (mod 3) to that trit as it leaves the first stage. Any single injected error therefore shows up on the flag in the same evaluation.

Top module: `tcopy_top`

## Requirements
- R1: With modeDual = 0, data trits 0, 1 and 2 equal A, and data trit 3 is 0. Data trit k sits at dataOut bits [2k+1:2k] and uses the binary codes 0, 1, 2.
- R2: With modeDual = 1, data trits 0 and 1 equal A, and data trits 2 and 3 equal B.
- R3: With modeDual = 0, parOut equals P.
- R4: With modeDual = 1, parOut equals (P + 2A + 2B) mod 3.
- R5: chkOut equals (R + the sum of the four data trits on dataOut) mod 3.
- R6: With injSel = 0 and R = (P + 1) mod 3, errOut is 0 for every legal input value.
- R7: Setting injSel[k] adds 1 (mod 3) to data trit k. With exactly one bit of injSel set and R = (P + 1) mod 3, errOut is 1.
- R8: With modeDual = 0, the value on B has no effect on dataOut or parOut.
- R9: With injSel = 0 and R not equal to (P + 1) mod 3, errOut is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| modeDual | input | 1 | 0: three copies of A; 1: two copies each of A and B |
| trA | input | 2 | Ternary source A |
| trB | input | 2 | Ternary source B (used only in dual mode) |
| parIn | input | 2 | Parity seed trit P |
| refIn | input | 2 | Reference trit R for the check stage |
| injSel | input | 4 | Per-data-trit fault injection (adds 1 mod 3) |
| dataOut | output | 8 | Four data trits, trit k at bits [2k+1:2k] |
| parOut | output | 2 | Weighted parity trit Q |
| chkOut | output | 2 | Check trit S |
| errOut | output | 1 | High when S is not the successor of Q |

## Verification
A wrong copy path or a wrong parity weight breaks the relation S = Q + 1. It therefore raises errOut together with the wrong data, in the same combinational settle, with no cycle of delay. The sweep covers every legal A, B, P, R and mode. At each point it applies no fault and then each single-line fault. This shows that a good state never raises the flag and that every single corruption does raise it. The sweep also compares each data trit, Q and S with arithmetic computed in the bench. A fault that happens to keep the parity relation would still show as a data or check-trit mismatch.

// File: rtl/tcopy_pkg.sv
package tcopy_pkg;
  localparam int TRIT_W = 2;
  localparam int DATA_N = 4;
  localparam int BUS_W  = TRIT_W * DATA_N;
  localparam int HALF_N = DATA_N / 2;

  typedef logic [TRIT_W-1:0] trit_t;

  // strobes from the mode decoder to the datapath stages
  typedef struct packed {
    logic  feedB;      // upper half of the slots carries B
    logic  blankLast;  // last slot is forced to zero
    trit_t weightA;    // parity weight applied to A
    trit_t weightB;    // parity weight applied to B
  } copyCtl_t;

  function automatic trit_t tAdd(trit_t x, trit_t y);
    logic [TRIT_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= 3'd3) s = s - 3'd3;
    return s[TRIT_W-1:0];
  endfunction

  function automatic trit_t tSucc(trit_t x);
    return tAdd(x, trit_t'(1));
  endfunction

  function automatic trit_t tMul(trit_t x, trit_t w);
    case (w)
      2'd1:    return x;
      2'd2:    return tAdd(x, x);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tcopy_ctrl.sv
module tcopy_ctrl
  import tcopy_pkg::*;
(
  input  logic     modeDual,
  output copyCtl_t ctl
);
  always_comb begin
    ctl.feedB     = modeDual;
    ctl.blankLast = !modeDual;
    // three copies of A weigh 3 = 0 (mod 3); two copies weigh 2
    ctl.weightA   = modeDual ? trit_t'(2) : trit_t'(0);
    ctl.weightB   = modeDual ? trit_t'(2) : trit_t'(0);
  end

  always_comb begin
    AST_STROBES_EXCLUSIVE: assert (ctl.feedB != ctl.blankLast); // R1
  end
endmodule

// File: rtl/tcopy_fanout.sv
module tcopy_fanout
  import tcopy_pkg::*;
(
  input  copyCtl_t          ctl,
  input  trit_t             aIn,
  input  trit_t             bIn,
  input  trit_t             pIn,
  input  logic [DATA_N-1:0] injSel,
  output logic [BUS_W-1:0]  dataBus,
  output trit_t             qOut
);
  for (genvar k = 0; k < DATA_N; k++) begin : gSlot
    trit_t src;
    if (k < HALF_N) begin : gLow
      assign src = aIn;
    end else if (k == DATA_N - 1) begin : gLast
      assign src = ctl.feedB ? bIn : (ctl.blankLast ? trit_t'(0) : aIn);
    end else begin : gHigh
      assign src = ctl.feedB ? bIn : aIn;
    end
    assign dataBus[k*TRIT_W +: TRIT_W] = injSel[k] ? tSucc(src) : src;
  end

  // parity taken from the sources with mode weights, not from the copies
  assign qOut = tAdd(pIn, tAdd(tMul(aIn, ctl.weightA), tMul(bIn, ctl.weightB)));
endmodule

// File: rtl/tcopy_check.sv
module tcopy_check
  import tcopy_pkg::*;
(
  input  logic [BUS_W-1:0] dataBus,
  input  trit_t            qIn,
  input  trit_t            rIn,
  output logic [BUS_W-1:0] passBus,
  output trit_t            sOut,
  output logic             errOut
);
  trit_t acc;

  always_comb begin
    acc = rIn;
    for (int k = 0; k < DATA_N; k++) acc = tAdd(acc, dataBus[k*TRIT_W +: TRIT_W]);
  end

  assign passBus = dataBus;
  assign sOut    = acc;
  assign errOut  = (sOut != tSucc(qIn));
endmodule

// File: rtl/tcopy_top.sv
module tcopy_top
  import tcopy_pkg::*;
(
  input  logic              modeDual,
  input  logic [TRIT_W-1:0] trA,
  input  logic [TRIT_W-1:0] trB,
  input  logic [TRIT_W-1:0] parIn,
  input  logic [TRIT_W-1:0] refIn,
  input  logic [DATA_N-1:0] injSel,
  output logic [BUS_W-1:0]  dataOut,
  output logic [TRIT_W-1:0] parOut,
  output logic [TRIT_W-1:0] chkOut,
  output logic              errOut
);
  copyCtl_t         ctl;
  logic [BUS_W-1:0] midBus;
  trit_t            qMid;

  tcopy_ctrl u_ctrl (.modeDual(modeDual), .ctl(ctl));

  tcopy_fanout u_fan (
    .ctl(ctl), .aIn(trA), .bIn(trB), .pIn(parIn), .injSel(injSel),
    .dataBus(midBus), .qOut(qMid)
  );

  tcopy_check u_chk (
    .dataBus(midBus), .qIn(qMid), .rIn(refIn),
    .passBus(dataOut), .sOut(chkOut), .errOut(errOut)
  );

  assign parOut = qMid;

  logic legalIn;
  assign legalIn = (trA != 2'd3) && (trB != 2'd3) && (parIn != 2'd3) && (refIn != 2'd3);

  always_comb begin
    if (legalIn) begin
      AST_SINGLE_LAST_ZERO: assert (modeDual || injSel[DATA_N-1] || dataOut[BUS_W-1 -: TRIT_W] == '0); // R1
      AST_DUAL_PAIRS: assert (!modeDual || injSel != '0 || (dataOut[1:0] == dataOut[3:2] && dataOut[5:4] == dataOut[7:6])); // R2
      AST_SINGLE_PARITY: assert (modeDual || parOut == parIn); // R3
      AST_CLEAN_NO_ERR: assert (injSel != '0 || refIn != tSucc(parIn) || !errOut); // R6
      AST_ONE_FAULT_FLAGGED: assert ($countones(injSel) != 1 || refIn != tSucc(parIn) || errOut); // R7
      AST_BAD_REF_FLAGGED: assert (injSel != '0 || refIn == tSucc(parIn) || errOut); // R9
    end
  end
endmodule

// File: tb/sim_tcopy_top.sv
module sim_tcopy_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       modeDual;
  logic [1:0] trA, trB, parIn, refIn;
  logic [3:0] injSel;
  logic [7:0] dataOut;
  logic [1:0] parOut, chkOut;
  logic       errOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic doneFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcopy_top u0 (
    .modeDual(modeDual), .trA(trA), .trB(trB), .parIn(parIn), .refIn(refIn),
    .injSel(injSel), .dataOut(dataOut), .parOut(parOut), .chkOut(chkOut), .errOut(errOut)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (mode=%0d A=%0d B=%0d P=%0d R=%0d inj=%b)",
               req, act, exp, modeDual, trA, trB, parIn, refIn, injSel);
    end
  endtask

  task automatic apply(input int md, input int a, input int b, input int p, input int r, input int inj);
    @(negedge clk);
    modeDual = md[0]; trA = a[1:0]; trB = b[1:0]; parIn = p[1:0]; refIn = r[1:0]; injSel = inj[3:0];
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !doneFlag) begin
      doneFlag = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // all-zero input state
    apply(0, 0, 0, 0, 0, 0);
    check("R1 zero-state data", int'(dataOut), 0);
    check("R3 zero-state parity", int'(parOut), 0);
    check("R9 zero-state err with R=P", int'(errOut), 1);

    for (int md = 0; md < 2; md++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int p = 0; p < 3; p++)
            for (int r = 0; r < 3; r++)
              for (int ii = 0; ii < 5; ii++) begin
                int inj, q, s, sum, errExp;
                int d[4];
                inj = (ii == 0) ? 0 : (1 << (ii - 1));
                apply(md, a, b, p, r, inj);
                d[0] = a; d[1] = a;
                d[2] = (md == 1) ? b : a;
                d[3] = (md == 1) ? b : 0;
                for (int k = 0; k < 4; k++) if (inj[k]) d[k] = (d[k] + 1) % 3;
                q = (md == 1) ? (p + 2*a + 2*b) % 3 : p;
                sum = r;
                for (int k = 0; k < 4; k++) sum += d[k];
                s = sum % 3;
                errExp = (s != (q + 1) % 3) ? 1 : 0;
                for (int k = 0; k < 4; k++)
                  check(inj != 0 ? "R7 data trit" : (md == 1 ? "R2 data trit" : "R1 data trit"),
                        int'(dataOut[2*k +: 2]), d[k]);
                check(md == 1 ? "R4 parity" : "R3 parity", int'(parOut), q);
                check("R5 check trit", int'(chkOut), s);
                if (inj == 0 && r == (p + 1) % 3) check("R6 clean err", int'(errOut), 0);
                else if (inj == 0)                check("R9 bad reference err", int'(errOut), 1);
                else if (r == (p + 1) % 3)        check("R7 injected err", int'(errOut), 1);
                else                              check("R5 err relation", int'(errOut), errExp);
                if (md == 0 && b != 0) begin
                  check("R8 B ignored data", int'(dataOut), d[0] + 4*d[1] + 16*d[2] + 64*d[3]);
                  check("R8 B ignored parity", int'(parOut), p);
                end
              end

    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule